// File: doc/BRIEF.md
# Multi-channel DMA result and status unit

This block is the host-facing register front end of a sixteen-channel DMA engine. Software places command pointers into a small per-channel queue. The engine takes them from that queue. When the engine finishes work on a channel, it reports an event carrying four flags: error, flush, done and user. The unit filters each event through the channel's configuration and keeps the events that pass in a per-channel result queue. It raises a per-channel pending bit, which can be read and is cleared by the same read. Each read of a channel's result register removes one stored result. A status word per channel reports the queue depths and readiness.

The host port is a plain 32-bit read/write port. Read data is registered and appears on the cycle after the read strobe. On the engine side, each channel presents its oldest command pointer and accepts a pop strobe. It also accepts a result-event strobe with a 4-bit flag field and a six-word state snapshot. An error event halts the channel until reset and captures the snapshot into six readable registers.

Top module: `dmx_hub`

## Requirements
- R1: After reset every queue is empty, every status word reads 0x00000001, every config word reads 0, the pending word reads 0 and `irq` is low.
- R2: Address bits [11:6] select a register group and bits [5:2] select the channel. The groups are: 0 command write, 1 result pop, 2..7 snapshot words 0..5, 8 status, 12 config, 14 pending word (channel field 0). Unmapped addresses read 0, and each channel's registers are independent of the other channels.
- R3: A command write is stored only when status bit 0 is high, which means the 2-entry command queue is not full and the channel is not halted. Any other command write is dropped.
- R4: `eng_cmd_avail[c]` is high while channel c holds a command, and `eng_cmd_head` slice c shows the oldest one. A pop strobe removes it in write order, and a pop on an empty queue has no effect.
- R5: The status word has bit 0 for command-ready, bit 1 for result-waiting, bits 28:27 for the number of queued commands and bits 31:29 for the number of queued results. All other bits are 0.
- R6: Event flags sit at bit 3 error, bit 2 flush, bit 1 done and bit 0 user. Error and user events are always kept. A done event is kept only when config bit 2 is set, and a flush event only when config bit 1 is set. Other events are discarded.
- R7: A result read returns {1'b1, 27'b0, flags} and removes that entry. A read of an empty result queue returns 0 and changes nothing.
- R8: The result queue holds 4 entries. An event that arrives while the queue is full is lost, and the entries already stored are kept.
- R9: A kept event that is stored sets the channel's pending bit when config bit 0 is set. `irq` is high while any pending bit is set.
- R10: A read of the pending word returns its value and clears it. A bit set in the same cycle as that read stays set.
- R11: An error event halts the channel until reset. While halted, status bit 0 reads low and command writes are dropped.
- R12: An error event loads snapshot registers 0..5 of its channel from `eng_snap` bits [c*192 + k*32 +: 32] for word k.
- R13: `hb_rdata` takes the read value on the clock edge that samples `hb_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_wr | input | 1 | Host write strobe |
| hb_rd | input | 1 | Host read strobe |
| hb_addr | input | 12 | Host byte address |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Registered host read data |
| irq | output | 1 | Any pending bit set |
| eng_cmd_avail | output | 16 | Per-channel command present |
| eng_cmd_head | output | 512 | Per-channel oldest command pointer, 32 bits each |
| eng_cmd_pop | input | 16 | Per-channel command pop strobe |
| eng_res_push | input | 16 | Per-channel result event strobe |
| eng_res_flags | input | 64 | Per-channel event flags, 4 bits each |
| eng_snap | input | 3072 | Per-channel six-word state snapshot |

## Verification
Two pairs of functions can meet in the same cycle. In the first pair, a host read of the pending word lands in the cycle where an engine event sets a new pending bit. In the second pair, a host pop of a result lands in the cycle where the engine pushes another result on the same channel. The bench drives both strobes in one cycle. It then checks that the read returned the state before that cycle, and that a following read shows the new bit or entry still present. A behavioural queue model, compared on every clock, judges the command pop and write that coincide on one channel.

// File: rtl/dmx_hub_pkg.sv
package dmx_hub_pkg;
    localparam int WORD_W = 32;
    localparam int SNAP_N = 6;
    localparam int GRP_W  = 6;

    localparam logic [GRP_W-1:0] GRP_CMD     = 6'd0;
    localparam logic [GRP_W-1:0] GRP_RES     = 6'd1;
    localparam logic [GRP_W-1:0] GRP_SNAP_LO = 6'd2;
    localparam logic [GRP_W-1:0] GRP_SNAP_HI = 6'd7;
    localparam logic [GRP_W-1:0] GRP_STAT    = 6'd8;
    localparam logic [GRP_W-1:0] GRP_CFG     = 6'd12;
    localparam logic [GRP_W-1:0] GRP_ISR     = 6'd14;

    typedef struct packed {
        logic err;
        logic flush;
        logic done;
        logic user;
    } res_flags_t;

    typedef struct packed {
        logic force_done;
        logic force_flush;
        logic irq_en;
    } chan_cfg_t;
endpackage

// File: rtl/hub_fifo.sv
module hub_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 2,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic     do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr           = bump(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
endmodule

// File: rtl/hub_chan.sv
module hub_chan
    import dmx_hub_pkg::*;
#(
    parameter int CMD_DEPTH = 2,
    parameter int RES_DEPTH = 4,
    localparam int CCW      = $clog2(CMD_DEPTH + 1),
    localparam int RCW      = $clog2(RES_DEPTH + 1),
    localparam int SNAP_W   = SNAP_N * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              cmd_pop,
    output logic              cmd_avail,
    output logic [WORD_W-1:0] cmd_head,
    input  logic              res_rd,
    output logic [WORD_W-1:0] res_word,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_wdata,
    output logic [WORD_W-1:0] cfg_word,
    input  logic              ev_push,
    input  res_flags_t        ev_flags,
    input  logic [SNAP_W-1:0] ev_snap,
    output logic [SNAP_W-1:0] snap_flat,
    output logic [WORD_W-1:0] status_word,
    output logic              res_stored,
    output logic              halted
);
    typedef struct packed {
        chan_cfg_t         cfg;
        logic              halt;
        logic [SNAP_W-1:0] snap;
    } chan_st_t;

    chan_st_t st_q, st_d;

    logic             cmd_full, cmd_empty;
    logic [CCW-1:0]   cmd_cnt;
    logic             res_full, res_empty;
    logic [RCW-1:0]   res_cnt;
    res_flags_t       res_head;
    logic             keep;
    logic             cmd_rdy;

    hub_fifo #(.W(WORD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (cmd_wr && !st_q.halt),
        .din   (cmd_data),
        .pop   (cmd_pop),
        .dout  (cmd_head),
        .count (cmd_cnt),
        .full  (cmd_full),
        .empty (cmd_empty)
    );

    hub_fifo #(.W(4), .DEPTH(RES_DEPTH)) u_resq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (keep),
        .din   (ev_flags),
        .pop   (res_rd),
        .dout  (res_head),
        .count (res_cnt),
        .full  (res_full),
        .empty (res_empty)
    );

    // Filter an engine event through the forced-result enables.
    always_comb begin
        keep = ev_push && (ev_flags.err || ev_flags.user
                           || (ev_flags.done  && st_q.cfg.force_done)
                           || (ev_flags.flush && st_q.cfg.force_flush));
    end

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.cfg = chan_cfg_t'(cfg_wdata);
        end
        if (ev_push && ev_flags.err) begin
            st_d.halt = 1'b1;
            st_d.snap = ev_snap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_rdy    = !cmd_full && !st_q.halt;
    assign cmd_avail  = !cmd_empty;
    assign res_stored = keep && !res_full;
    assign halted     = st_q.halt;
    assign snap_flat  = st_q.snap;
    assign cfg_word   = {{(WORD_W-3){1'b0}}, st_q.cfg};
    assign res_word   = res_empty ? '0 : {1'b1, {(WORD_W-5){1'b0}}, res_head};

    always_comb begin
        status_word        = '0;
        status_word[31:29] = 3'(res_cnt);
        status_word[28:27] = 2'(cmd_cnt);
        status_word[1]     = !res_empty;
        status_word[0]     = cmd_rdy;
    end
endmodule

// File: rtl/dmx_hub.sv
module dmx_hub
    import dmx_hub_pkg::*;
#(
    parameter int NCH       = 16,
    parameter int CMD_DEPTH = 2,
    parameter int RES_DEPTH = 4,
    parameter int ADDR_W    = 12,
    localparam int CH_W     = $clog2(NCH),
    localparam int SNAP_W   = SNAP_N * WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hb_wr,
    input  logic                    hb_rd,
    input  logic [ADDR_W-1:0]       hb_addr,
    input  logic [WORD_W-1:0]       hb_wdata,
    output logic [WORD_W-1:0]       hb_rdata,
    output logic                    irq,
    output logic [NCH-1:0]          eng_cmd_avail,
    output logic [NCH*WORD_W-1:0]   eng_cmd_head,
    input  logic [NCH-1:0]          eng_cmd_pop,
    input  logic [NCH-1:0]          eng_res_push,
    input  logic [NCH*4-1:0]        eng_res_flags,
    input  logic [NCH*SNAP_W-1:0]   eng_snap
);
    typedef struct packed {
        logic [NCH-1:0]    isr;
        logic [WORD_W-1:0] rdata;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [GRP_W-1:0]  grp;
    logic [CH_W-1:0]   ch_sel;
    logic              addr_unused;
    logic              rd_isr;
    logic [WORD_W-1:0] rd_val;
    logic [2:0]        snap_idx;
    logic [7:0]        snap_off;

    logic [WORD_W-1:0] res_word_a [NCH];
    logic [WORD_W-1:0] status_a   [NCH];
    logic [WORD_W-1:0] cfg_a      [NCH];
    logic [SNAP_W-1:0] snap_a     [NCH];
    logic [NCH-1:0]    stored_v;
    logic [NCH-1:0]    irq_en_v;
    logic [NCH-1:0]    halt_v;
    logic [NCH-1:0]    isr_v;

    assign grp         = hb_addr[ADDR_W-1 -: GRP_W];
    assign ch_sel      = hb_addr[2 +: CH_W];
    assign addr_unused = ^hb_addr[1:0];
    assign rd_isr      = hb_rd && (grp == GRP_ISR) && (hb_addr[5:2] == 4'd0);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = (ch_sel == CH_W'(c));

        hub_chan #(.CMD_DEPTH(CMD_DEPTH), .RES_DEPTH(RES_DEPTH)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .cmd_wr      (hb_wr && sel && (grp == GRP_CMD)),
            .cmd_data    (hb_wdata),
            .cmd_pop     (eng_cmd_pop[c]),
            .cmd_avail   (eng_cmd_avail[c]),
            .cmd_head    (eng_cmd_head[c*WORD_W +: WORD_W]),
            .res_rd      (hb_rd && sel && (grp == GRP_RES)),
            .res_word    (res_word_a[c]),
            .cfg_wr      (hb_wr && sel && (grp == GRP_CFG)),
            .cfg_wdata   (hb_wdata[2:0]),
            .cfg_word    (cfg_a[c]),
            .ev_push     (eng_res_push[c]),
            .ev_flags    (res_flags_t'(eng_res_flags[c*4 +: 4])),
            .ev_snap     (eng_snap[c*SNAP_W +: SNAP_W]),
            .snap_flat   (snap_a[c]),
            .status_word (status_a[c]),
            .res_stored  (stored_v[c]),
            .halted      (halt_v[c])
        );

        assign irq_en_v[c] = cfg_a[c][0];
    end

    // Read mux over the pre-edge state of the addressed register.
    always_comb begin
        rd_val   = '0;
        snap_idx = 3'(grp - GRP_SNAP_LO);
        snap_off = {snap_idx, 5'b0};
        if (grp == GRP_RES) begin
            rd_val = res_word_a[ch_sel];
        end else if (grp >= GRP_SNAP_LO && grp <= GRP_SNAP_HI) begin
            rd_val = snap_a[ch_sel][snap_off +: WORD_W];
        end else if (grp == GRP_STAT) begin
            rd_val = status_a[ch_sel];
        end else if (grp == GRP_CFG) begin
            rd_val = cfg_a[ch_sel];
        end else if (grp == GRP_ISR && hb_addr[5:2] == 4'd0) begin
            rd_val = WORD_W'(st_q.isr);
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_isr) st_d.isr = stored_v & irq_en_v;
        else        st_d.isr = st_q.isr | (stored_v & irq_en_v);
        if (hb_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isr_v    = st_q.isr;
    assign irq      = |st_q.isr;
    assign hb_rdata = st_q.rdata;
endmodule

// File: rtl/hub_checks.sv
module hub_checks #(
    parameter int NCH    = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hb_wr,
    input logic              hb_rd,
    input logic [ADDR_W-1:0] hb_addr,
    input logic [NCH-1:0]    eng_res_push,
    input logic [NCH-1:0]    eng_cmd_avail,
    input logic [NCH-1:0]    isr_v,
    input logic [NCH-1:0]    halt_v
);
    logic rd_isr;
    assign rd_isr = hb_rd && (hb_addr[ADDR_W-1 -: 6] == 6'd14) && (hb_addr[5:2] == 4'd0);

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((halt_v & $past(halt_v)) == $past(halt_v)));

    assert_halt_no_new_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((halt_v & $past(halt_v) & eng_cmd_avail & ~$past(eng_cmd_avail)) == '0));

    assert_pending_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (((isr_v & ~$past(isr_v)) & ~$past(eng_res_push)) == '0));

    assert_pending_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_isr) |-> ((isr_v & ~$past(eng_res_push)) == '0));

    assert_cmd_from_host_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((eng_cmd_avail & ~$past(eng_cmd_avail)) != '0) |-> $past(hb_wr));
endmodule

bind dmx_hub hub_checks #(.NCH(NCH), .ADDR_W(ADDR_W)) u_checks (
    .clk           (clk),
    .rst_n         (rst_n),
    .hb_wr         (hb_wr),
    .hb_rd         (hb_rd),
    .hb_addr       (hb_addr),
    .eng_res_push  (eng_res_push),
    .eng_cmd_avail (eng_cmd_avail),
    .isr_v         (isr_v),
    .halt_v        (halt_v)
);

// File: tb/tb_dmx_hub.sv
`timescale 1ns/1ps
module tb_dmx_hub;
    localparam int NCH = 16;
    localparam int SNW = 192;
    localparam logic [3:0] F_USER = 4'b0001, F_DONE = 4'b0010, F_FLUSH = 4'b0100, F_ERR = 4'b1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic                  hb_wr = 1'b0, hb_rd = 1'b0;
    logic [11:0]           hb_addr = '0;
    logic [31:0]           hb_wdata = '0;
    logic [31:0]           hb_rdata;
    logic                  irq;
    logic [NCH-1:0]        eng_cmd_avail;
    logic [NCH*32-1:0]     eng_cmd_head;
    logic [NCH-1:0]        eng_cmd_pop = '0, eng_res_push = '0;
    logic [NCH*4-1:0]      eng_res_flags = '0;
    logic [NCH*SNW-1:0]    eng_snap = '0;

    dmx_hub dut (
        .clk(clk), .rst_n(rst_n), .hb_wr(hb_wr), .hb_rd(hb_rd), .hb_addr(hb_addr),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .irq(irq),
        .eng_cmd_avail(eng_cmd_avail), .eng_cmd_head(eng_cmd_head), .eng_cmd_pop(eng_cmd_pop),
        .eng_res_push(eng_res_push), .eng_res_flags(eng_res_flags), .eng_snap(eng_snap)
    );

    int tests = 0, fails = 0;

    // Behavioural reference model
    logic [31:0]    m_cmd [NCH][$];
    logic [3:0]     m_res [NCH][$];
    logic [2:0]     m_cfg [NCH];
    bit             m_halt [NCH];
    logic [31:0]    m_snap [NCH][6];
    logic [NCH-1:0] m_isr = '0;
    logic [31:0]    m_rdata = '0;

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_cfg[c] = '0;
            m_halt[c] = 1'b0;
            for (int k = 0; k < 6; k++) m_snap[c][k] = '0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] ra(input int grp, input int ch);
        return 12'((grp << 6) | (ch << 2));
    endfunction

    function automatic logic [31:0] mread(input logic [11:0] a);
        int grp = int'(a[11:6]);
        int ch  = int'(a[5:2]);
        logic [31:0] v = '0;
        if (grp == 1) begin
            if (m_res[ch].size() != 0) v = {1'b1, 27'b0, m_res[ch][0]};
        end else if (grp >= 2 && grp <= 7) begin
            v = m_snap[ch][grp-2];
        end else if (grp == 8) begin
            v[31:29] = 3'(m_res[ch].size());
            v[28:27] = 2'(m_cmd[ch].size());
            v[1]     = (m_res[ch].size() != 0);
            v[0]     = (m_cmd[ch].size() < 2) && !m_halt[ch];
        end else if (grp == 12) begin
            v = {29'b0, m_cfg[ch]};
        end else if (grp == 14 && ch == 0) begin
            v = 32'(m_isr);
        end
        return v;
    endfunction

    task automatic model_step();
        int pc[NCH];
        int pr[NCH];
        bit ph[NCH];
        logic [2:0] pcfg[NCH];
        logic [NCH-1:0] set_v = '0;
        logic [31:0] rv;
        logic [3:0] f;
        bit keep;
        int grp = int'(hb_addr[11:6]);
        int ch  = int'(hb_addr[5:2]);
        rv = mread(hb_addr);
        for (int c = 0; c < NCH; c++) begin
            pc[c] = m_cmd[c].size(); pr[c] = m_res[c].size();
            ph[c] = m_halt[c];       pcfg[c] = m_cfg[c];
        end
        for (int c = 0; c < NCH; c++)
            if (eng_cmd_pop[c] && pc[c] > 0) void'(m_cmd[c].pop_front());
        if (hb_wr && grp == 0 && pc[ch] < 2 && !ph[ch]) m_cmd[ch].push_back(hb_wdata);
        if (hb_rd && grp == 1 && pr[ch] > 0) void'(m_res[ch].pop_front());
        for (int c = 0; c < NCH; c++) begin
            if (eng_res_push[c]) begin
                f = eng_res_flags[c*4 +: 4];
                keep = f[3] || f[0] || (f[1] && pcfg[c][2]) || (f[2] && pcfg[c][1]);
                if (keep && pr[c] < 4) begin
                    m_res[c].push_back(f);
                    if (pcfg[c][0]) set_v[c] = 1'b1;
                end
                if (f[3]) begin
                    m_halt[c] = 1'b1;
                    for (int k = 0; k < 6; k++) m_snap[c][k] = eng_snap[c*SNW + k*32 +: 32];
                end
            end
        end
        if (hb_wr && grp == 12) m_cfg[ch] = hb_wdata[2:0];
        if (hb_rd && grp == 14 && ch == 0) m_isr = set_v;
        else                               m_isr = m_isr | set_v;
        if (hb_rd) m_rdata = rv;
    endtask

    // One clock: update model, wait for the edge, compare away from it.
    task automatic cycle(input string tag);
        logic [NCH-1:0] exp_av;
        model_step();
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++) exp_av[c] = (m_cmd[c].size() != 0);
        chk(eng_cmd_avail == exp_av, "R4 avail", 32'(eng_cmd_avail), 32'(exp_av));
        for (int c = 0; c < NCH; c++)
            if (exp_av[c]) chk(eng_cmd_head[c*32 +: 32] == m_cmd[c][0], "R4 head",
                               eng_cmd_head[c*32 +: 32], m_cmd[c][0]);
        chk(irq == (m_isr != '0), "R9 irq", 32'(irq), 32'(m_isr != '0));
        chk(hb_rdata == m_rdata, tag, hb_rdata, m_rdata);
        hb_wr = 1'b0; hb_rd = 1'b0; eng_cmd_pop = '0; eng_res_push = '0;
    endtask

    task automatic hwrite(input int grp, input int ch, input logic [31:0] d, input string tag);
        hb_wr = 1'b1; hb_addr = ra(grp, ch); hb_wdata = d;
        cycle(tag);
    endtask

    task automatic hread_exp(input int grp, input int ch, input logic [31:0] exp, input string tag);
        hb_rd = 1'b1; hb_addr = ra(grp, ch);
        cycle(tag);
        chk(hb_rdata == exp, tag, hb_rdata, exp);
    endtask

    task automatic epush(input int ch, input logic [3:0] f);
        eng_res_push[ch] = 1'b1;
        eng_res_flags[ch*4 +: 4] = f;
        cycle("R6 event");
    endtask

    task automatic epop(input int ch);
        eng_cmd_pop[ch] = 1'b1;
        cycle("R4 pop");
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        cycle("R1 idle");
        // R1 reset state
        hread_exp(8, 0, 32'h1, "R1 status ch0");
        hread_exp(8, 15, 32'h1, "R1 status ch15");
        hread_exp(12, 4, 32'h0, "R1 cfg");
        hread_exp(14, 0, 32'h0, "R1 pending");
        // R2 map and per-channel independence
        hwrite(12, 3, 32'h7, "R2 cfg wr");
        hwrite(12, 7, 32'h1, "R2 cfg wr");
        hwrite(12, 9, 32'h1, "R2 cfg wr");
        hread_exp(12, 3, 32'h7, "R2 cfg ch3");
        hread_exp(12, 2, 32'h0, "R2 cfg ch2");
        hread_exp(12, 15, 32'h0, "R2 cfg ch15");
        hread_exp(10, 3, 32'h0, "R2 unmapped");
        // R3 R5 command queue depth and drop
        hwrite(0, 3, 32'hA000_0001, "R3 cmd");
        hwrite(0, 3, 32'hA000_0002, "R3 cmd");
        hwrite(0, 3, 32'hA000_0003, "R3 cmd drop");
        hread_exp(8, 3, 32'h1000_0000, "R5 status full");
        epop(3);
        hwrite(0, 3, 32'hA000_0004, "R3 cmd");
        hread_exp(8, 3, 32'h1000_0000, "R3 status");
        epop(3);
        epop(3);
        epop(3);
        // write and pop in one cycle on an empty then non-empty queue
        hb_wr = 1'b1; hb_addr = ra(0, 0); hb_wdata = 32'hB0; eng_cmd_pop[0] = 1'b1; cycle("R4 wr+pop empty");
        hb_wr = 1'b1; hb_addr = ra(0, 0); hb_wdata = 32'hB1; eng_cmd_pop[0] = 1'b1; cycle("R4 wr+pop");
        epop(0);
        // R6 filtering
        epush(3, F_DONE);
        epush(3, F_FLUSH);
        epush(5, F_DONE);
        epush(5, F_FLUSH);
        epush(5, F_USER);
        hread_exp(8, 5, 32'h2000_0003, "R6 status ch5");
        hread_exp(1, 5, 32'h8000_0001, "R7 user result");
        hread_exp(1, 5, 32'h0, "R7 empty read");
        hread_exp(1, 3, 32'h8000_0002, "R7 done result");
        hread_exp(1, 3, 32'h8000_0004, "R7 flush result");
        hread_exp(14, 0, 32'h8, "R9 pending ch3");
        hread_exp(14, 0, 32'h0, "R10 cleared");
        // R8 overflow
        epush(3, F_USER); epush(3, F_DONE); epush(3, F_USER); epush(3, F_FLUSH);
        epush(3, F_DONE);
        hread_exp(8, 3, 32'h8000_0003, "R8 status full");
        hread_exp(1, 3, 32'h8000_0001, "R8 entry0");
        hread_exp(1, 3, 32'h8000_0002, "R8 entry1");
        hread_exp(1, 3, 32'h8000_0001, "R8 entry2");
        hread_exp(1, 3, 32'h8000_0004, "R8 entry3");
        hread_exp(1, 3, 32'h0, "R8 drained");
        hread_exp(14, 0, 32'h8, "R9 pending again");
        // R10 pending read meets a new event
        hb_rd = 1'b1; hb_addr = ra(14, 0); eng_res_push[7] = 1'b1; eng_res_flags[7*4 +: 4] = F_USER;
        cycle("R10 same cycle");
        chk(hb_rdata == 32'h0, "R10 same-cycle value", hb_rdata, 32'h0);
        hread_exp(14, 0, 32'h80, "R10 kept bit");
        // result pop meets a push on the same channel
        hb_rd = 1'b1; hb_addr = ra(1, 7); eng_res_push[7] = 1'b1; eng_res_flags[7*4 +: 4] = F_ERR;
        eng_snap[7*SNW +: SNW] = {6{32'h7777_0000}};
        cycle("R7 pop+push");
        chk(hb_rdata == 32'h8000_0001, "R7 pop+push value", hb_rdata, 32'h8000_0001);
        hread_exp(8, 7, 32'h2000_0002, "R11 status ch7");
        // R11 R12 error halt and snapshot
        for (int k = 0; k < 6; k++) eng_snap[9*SNW + k*32 +: 32] = 32'hC0DE_0900 + 32'(k);
        epush(9, F_ERR | F_DONE);
        hread_exp(1, 9, 32'h8000_000A, "R11 error result");
        hread_exp(8, 9, 32'h0, "R11 halted status");
        hwrite(0, 9, 32'hDEAD_0009, "R11 cmd dropped");
        hread_exp(8, 9, 32'h0, "R11 still empty");
        for (int k = 0; k < 6; k++)
            hread_exp(2 + k, 9, 32'hC0DE_0900 + 32'(k), "R12 snapshot");
        hread_exp(2, 8, 32'h0, "R12 other channel");
        hread_exp(14, 0, 32'h280, "R9 pending ch7 ch9");
        // R13 read data holds between reads
        cycle("R13 hold");
        chk(hb_rdata == 32'h280, "R13 hold", hb_rdata, 32'h280);
        finish_run();
    end
endmodule